// File: doc/BRIEF.md
# Two-step register renamer with late physical binding

This block renames destination registers for an out-of-order core in two stages. When an instruction is decoded, its logical destination gets a virtual tag taken from a tag pool. The tag only records which instruction produces which value. The source operands are looked up as virtual tags in the same cycle. No storage register is taken at decode. A physical register is bound to the virtual tag only when the instruction writes its result. The tag-to-physical table keeps that binding, so a consumer's lookup shows whether its producer's value has a home yet.

Physical registers are scarce, so the write-back grant follows a fixed policy:
- A normal instruction may draw from the free pool only while more than a reserved count of registers remain. Only the oldest in-flight instruction may use that reserve, so the core cannot deadlock.
- When nothing can be drawn, the requester takes the register held by the youngest completed instruction that is younger than itself. That victim loses its result and must write back again.
- When no such victim exists, the requester is told to replay. It does not wait in place.

Commit retires the oldest entry and returns the previous tag and register of its logical destination. A flush returns the maps to the committed state and reclaims every speculative tag and register.

Top module: `vpr_renamer`

## Requirements
- R1: After reset, logical register i maps to virtual tag i, and tag i is bound to physical register i. For the defaults, dec_vp reads 32, dec_tag reads 0, and dec_ready is high.
- R2: A decode that fires gives its destination the lowest-numbered free virtual tag, shown on dec_vp, and the reorder slot shown on dec_tag. Each source lookup returns the mapping as it stood before this instruction: its tag, the physical register bound to that tag, and a bound flag. Decode never changes the number of free physical registers.
- R3: dec_ready is low when the reorder record holds NROB entries or no virtual tag is free. A decode offered while dec_ready is low changes no state.
- R4: A write-back for an in-flight, not-yet-completed slot, made while more than NRR physical registers are free, is granted the lowest-numbered free register. Later lookups of that instruction's tag show the register with the bound flag set.
- R5: When NRR or fewer physical registers are free, only the write-back of the oldest slot (the commit head) may take a free register from the reserve. It takes the lowest-numbered one.
- R6: A write-back that cannot use the pool takes the register of the completed slot that is youngest of all slots younger than itself. It raises wb_steal with that slot on wb_victim. The victim returns to not-completed and its tag becomes unbound.
- R7: A write-back that can neither draw nor steal raises wb_replay, gets no register, and leaves the slot not-completed.
- R8: cm_ok is high only when cm_valid is asserted and the head slot has completed. Commit advances the head, records the head's tag as the committed mapping, and frees the previous tag of that logical register and its physical register.
- R9: A flush empties the reorder record, so dec_tag reads 0 next cycle. It sets each logical mapping to the committed tag with its register still bound. Every tag and register not in the committed state is freed. Decode, write-back and commit in the same cycle are ignored.
- R10: A write-back naming an empty slot, or a slot that has already completed, is ignored: no grant, no replay, and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | An instruction is offered for renaming |
| dec_dst | input | LW | Logical destination |
| dec_src_a | input | LW | First logical source |
| dec_src_b | input | LW | Second logical source |
| dec_ready | output | 1 | A decode can be accepted this cycle |
| dec_vp | output | VW | Virtual tag given to the destination |
| dec_tag | output | RW | Reorder slot (age tag) of the instruction |
| src_a_vp | output | VW | Virtual tag of the first source |
| src_a_preg | output | PW | Physical register bound to that tag |
| src_a_bound | output | 1 | First source tag has a physical register |
| src_b_vp | output | VW | Virtual tag of the second source |
| src_b_preg | output | PW | Physical register bound to that tag |
| src_b_bound | output | 1 | Second source tag has a physical register |
| wb_valid | input | 1 | Write-back requests a physical register |
| wb_tag | input | RW | Reorder slot (age) of the requester |
| wb_grant | output | 1 | A register was granted |
| wb_preg | output | PW | Granted register (0 when none) |
| wb_steal | output | 1 | The grant was taken from a younger slot |
| wb_victim | output | RW | Slot that lost its register (0 when none) |
| wb_replay | output | 1 | No register was available; re-execute |
| cm_valid | input | 1 | Commit request for the head slot |
| cm_ok | output | 1 | Head slot committed this cycle |
| flush | input | 1 | Discard all speculative state |

## Verification
All responses are combinational on the current state and the current inputs. The rename outputs, the grant, steal, replay and commit signals are therefore due in the same cycle as the stimulus. The effect of a stimulus on the maps, the free pools and the reorder record shows in the lookups and grants of the next cycle. The bench drives inputs at the falling edge and samples one time unit later, still in that cycle. At each rising edge the bench advances its behavioural model and does not sample at the edge itself. Directed sequences drain the pool into the reserve, force a steal, a replay and a reserve grant, and then commit and flush. A long pseudo-random run follows, and every output is compared in every cycle.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  // Distance of a ring slot from the head: 0 is the oldest in flight.
  function automatic int unsigned ring_age(int unsigned idx, int unsigned head,
                                           int unsigned depth);
    return (idx + depth - head) % depth;
  endfunction
endpackage

// File: rtl/vpr_freelist.sv
module vpr_freelist #(
  parameter int N         = 64,
  parameter int INIT_USED = 32,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          put,
  input  logic [IW-1:0] put_idx,
  input  logic          restore,
  input  logic [N-1:0]  restore_used,
  output logic          any,
  output logic [IW-1:0] low_idx,
  output logic [CW-1:0] count
);
  logic [N-1:0] free_q, free_d;

  always_comb begin
    any     = 1'b0;
    low_idx = '0;
    count   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        any     = 1'b1;
        low_idx = IW'(i);
      end
    end
    for (int i = 0; i < N; i++) count = count + CW'(free_q[i]);
  end

  always_comb begin
    free_d = free_q;
    if (restore) begin
      free_d = ~restore_used;
    end else begin
      if (take) free_d[low_idx] = 1'b0;
      if (put)  free_d[put_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) free_q[i] <= (i >= INIT_USED);
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/vpr_rob.sv
module vpr_rob
  import vpr_pkg::*;
#(
  parameter int NROB = 16,
  parameter int LW   = 5,
  parameter int VW   = 6,
  localparam int RW  = $clog2(NROB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [LW-1:0] push_log,
  input  logic [VW-1:0] push_vp,
  input  logic [VW-1:0] push_prev,
  input  logic          fin,
  input  logic [RW-1:0] fin_idx,
  input  logic          undo,
  input  logic [RW-1:0] undo_idx,
  input  logic          pop,
  input  logic [RW-1:0] req_idx,
  output logic [RW-1:0] head,
  output logic [RW-1:0] tail,
  output logic [RW:0]   cnt,
  output logic          head_valid,
  output logic          head_done,
  output logic [LW-1:0] head_log,
  output logic [VW-1:0] head_vp,
  output logic [VW-1:0] head_prev,
  output logic          req_valid,
  output logic          req_done,
  output logic [VW-1:0] req_vp,
  output logic [RW-1:0] req_age,
  output logic          victim_ok,
  output logic [RW-1:0] victim_idx,
  output logic [VW-1:0] victim_vp,
  output logic [RW-1:0] victim_age
);
  logic [NROB-1:0] ent_v, ent_done;
  logic [LW-1:0]   ent_log  [NROB];
  logic [VW-1:0]   ent_vp   [NROB];
  logic [VW-1:0]   ent_prev [NROB];
  int unsigned     best_age;

  assign head_valid = ent_v[head];
  assign head_done  = ent_done[head];
  assign head_log   = ent_log[head];
  assign head_vp    = ent_vp[head];
  assign head_prev  = ent_prev[head];
  assign req_valid  = ent_v[req_idx];
  assign req_done   = ent_done[req_idx];
  assign req_vp     = ent_vp[req_idx];
  assign req_age    = RW'(ring_age(int'(req_idx), int'(head), NROB));
  assign victim_vp  = ent_vp[victim_idx];
  assign victim_age = RW'(best_age);

  // Youngest completed slot strictly younger than the requester.
  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = '0;
    best_age   = ring_age(int'(req_idx), int'(head), NROB);
    for (int j = 0; j < NROB; j++) begin
      if (ent_v[j] && ent_done[j] &&
          ring_age(j, int'(head), NROB) > best_age) begin
        victim_ok  = 1'b1;
        victim_idx = RW'(j);
        best_age   = ring_age(j, int'(head), NROB);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_v    <= '0;
      ent_done <= '0;
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
    end else begin
      if (push) begin
        ent_v[tail]    <= 1'b1;
        ent_done[tail] <= 1'b0;
        ent_log[tail]  <= push_log;
        ent_vp[tail]   <= push_vp;
        ent_prev[tail] <= push_prev;
        tail           <= tail + 1'b1;
      end
      if (fin)  ent_done[fin_idx]  <= 1'b1;
      if (undo) ent_done[undo_idx] <= 1'b0;
      if (pop) begin
        ent_v[head] <= 1'b0;
        head        <= head + 1'b1;
      end
      cnt <= cnt + (RW+1)'(push) - (RW+1)'(pop);
    end
  end
endmodule

// File: rtl/vpr_renamer.sv
module vpr_renamer #(
  parameter int NLOG  = 32,
  parameter int NVP   = 64,
  parameter int NPHYS = 48,
  parameter int NRR   = 4,
  parameter int NROB  = 16,
  localparam int LW  = $clog2(NLOG),
  localparam int VW  = $clog2(NVP),
  localparam int PW  = $clog2(NPHYS),
  localparam int RW  = $clog2(NROB),
  localparam int PCW = $clog2(NPHYS + 1),
  localparam int VCW = $clog2(NVP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [LW-1:0] dec_dst,
  input  logic [LW-1:0] dec_src_a,
  input  logic [LW-1:0] dec_src_b,
  output logic          dec_ready,
  output logic [VW-1:0] dec_vp,
  output logic [RW-1:0] dec_tag,
  output logic [VW-1:0] src_a_vp,
  output logic [PW-1:0] src_a_preg,
  output logic          src_a_bound,
  output logic [VW-1:0] src_b_vp,
  output logic [PW-1:0] src_b_preg,
  output logic          src_b_bound,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_tag,
  output logic          wb_grant,
  output logic [PW-1:0] wb_preg,
  output logic          wb_steal,
  output logic [RW-1:0] wb_victim,
  output logic          wb_replay,
  input  logic          cm_valid,
  output logic          cm_ok,
  input  logic          flush
);
  // Speculative and committed logical-to-tag maps, tag-to-physical map.
  logic [VW-1:0]  gmap [NLOG];
  logic [VW-1:0]  cmap [NLOG];
  logic [PW-1:0]  vp2p [NVP];
  logic [NVP-1:0] vbound;

  // Named internal events, also watched by the checker.
  logic           dec_fire, wb_hit, req_oldest, pool_open, use_free;
  logic [RW-1:0]  rob_head, req_age, victim_age, victim_idx;
  logic [RW:0]    rob_cnt;
  logic [PCW-1:0] pfree_cnt;
  logic [VCW-1:0] vfree_cnt;
  logic           vfree_any, pfree_any;
  logic [VW-1:0]  vfree_low;
  logic [PW-1:0]  pfree_low;
  logic           head_valid, head_done, req_valid, req_done, victim_ok;
  logic [LW-1:0]  head_log;
  logic [VW-1:0]  head_vp, head_prev, req_vp, victim_vp;
  logic [NVP-1:0]   vused;
  logic [NPHYS-1:0] pused;

  assign dec_ready  = (rob_cnt != (RW+1)'(NROB)) && vfree_any;
  assign dec_fire   = dec_valid && dec_ready && !flush;
  assign dec_vp     = vfree_low;

  assign src_a_vp    = gmap[dec_src_a];
  assign src_a_preg  = vp2p[src_a_vp];
  assign src_a_bound = vbound[src_a_vp];
  assign src_b_vp    = gmap[dec_src_b];
  assign src_b_preg  = vp2p[src_b_vp];
  assign src_b_bound = vbound[src_b_vp];

  assign wb_hit     = wb_valid && !flush && req_valid && !req_done;
  assign req_oldest = (wb_tag == rob_head);
  assign pool_open  = pfree_cnt > PCW'(NRR);
  assign use_free   = wb_hit && (pool_open || (req_oldest && pfree_any));
  assign wb_steal   = wb_hit && !use_free && victim_ok;
  assign wb_replay  = wb_hit && !use_free && !victim_ok;
  assign wb_grant   = use_free || wb_steal;
  assign wb_preg    = use_free ? pfree_low : (wb_steal ? vp2p[victim_vp] : '0);
  assign wb_victim  = wb_steal ? victim_idx : '0;

  assign cm_ok = cm_valid && !flush && head_valid && head_done;

  // Committed footprint, used to rebuild the free pools on a flush.
  always_comb begin
    vused = '0;
    pused = '0;
    for (int i = 0; i < NLOG; i++) begin
      vused[cmap[i]]       = 1'b1;
      pused[vp2p[cmap[i]]] = 1'b1;
    end
  end

  vpr_freelist #(.N(NVP), .INIT_USED(NLOG)) i_vfree (
    .clk(clk), .rst(rst), .take(dec_fire), .put(cm_ok), .put_idx(head_prev),
    .restore(flush), .restore_used(vused),
    .any(vfree_any), .low_idx(vfree_low), .count(vfree_cnt)
  );

  vpr_freelist #(.N(NPHYS), .INIT_USED(NLOG)) i_pfree (
    .clk(clk), .rst(rst), .take(use_free), .put(cm_ok), .put_idx(vp2p[head_prev]),
    .restore(flush), .restore_used(pused),
    .any(pfree_any), .low_idx(pfree_low), .count(pfree_cnt)
  );

  vpr_rob #(.NROB(NROB), .LW(LW), .VW(VW)) i_rob (
    .clk(clk), .rst(rst), .flush(flush),
    .push(dec_fire), .push_log(dec_dst), .push_vp(dec_vp), .push_prev(gmap[dec_dst]),
    .fin(wb_grant), .fin_idx(wb_tag), .undo(wb_steal), .undo_idx(victim_idx),
    .pop(cm_ok), .req_idx(wb_tag),
    .head(rob_head), .tail(dec_tag), .cnt(rob_cnt),
    .head_valid(head_valid), .head_done(head_done), .head_log(head_log),
    .head_vp(head_vp), .head_prev(head_prev),
    .req_valid(req_valid), .req_done(req_done), .req_vp(req_vp), .req_age(req_age),
    .victim_ok(victim_ok), .victim_idx(victim_idx), .victim_vp(victim_vp),
    .victim_age(victim_age)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLOG; i++) begin
        gmap[i] <= VW'(i);
        cmap[i] <= VW'(i);
      end
      for (int v = 0; v < NVP; v++) begin
        vp2p[v]   <= (v < NLOG) ? PW'(v) : '0;
        vbound[v] <= (v < NLOG);
      end
    end else if (flush) begin
      for (int i = 0; i < NLOG; i++) gmap[i] <= cmap[i];
      vbound <= vused;
    end else begin
      if (dec_fire) begin
        gmap[dec_dst]  <= dec_vp;
        vbound[dec_vp] <= 1'b0;
      end
      if (wb_grant) begin
        vp2p[req_vp]   <= wb_preg;
        vbound[req_vp] <= 1'b1;
      end
      if (wb_steal) vbound[victim_vp] <= 1'b0;
      if (cm_ok) begin
        cmap[head_log]    <= head_vp;
        vbound[head_prev] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpr_renamer_chk.sv
module vpr_renamer_chk #(
  parameter int NROB = 16,
  parameter int NRR  = 4,
  parameter int PCW  = 6,
  localparam int RW  = $clog2(NROB)
) (
  input logic           clk,
  input logic           rst,
  input logic           dec_valid,
  input logic           dec_ready,
  input logic           dec_fire,
  input logic [RW-1:0]  dec_tag,
  input logic           flush,
  input logic           wb_grant,
  input logic           wb_steal,
  input logic [RW-1:0]  wb_tag,
  input logic [RW-1:0]  rob_head,
  input logic [RW:0]    rob_cnt,
  input logic [PCW-1:0] pfree_cnt,
  input logic [RW-1:0]  req_age,
  input logic [RW-1:0]  victim_age,
  input logic           cm_ok
);
  assert_decode_keeps_pool_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && !wb_grant && !cm_ok) |=> $stable(pfree_cnt));

  assert_stall_holds_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready && !flush) |=> (dec_tag == $past(dec_tag)));

  assert_reserve_head_only_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_grant && !wb_steal && pfree_cnt <= PCW'(NRR)) |-> (wb_tag == rob_head));

  assert_pool_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_grant && !wb_steal && wb_tag != rob_head) |=> (pfree_cnt >= PCW'(NRR)));

  assert_victim_younger_R6: assert property (@(posedge clk) disable iff (rst)
    wb_steal |-> (victim_age > req_age));

  assert_commit_advances_R8: assert property (@(posedge clk) disable iff (rst)
    cm_ok |=> (rob_head == RW'($past(rob_head) + 1'b1)));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rob_cnt == '0 && dec_tag == '0));
endmodule

bind vpr_renamer vpr_renamer_chk #(.NROB(NROB), .NRR(NRR), .PCW(PCW)) i_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_ready(dec_ready),
  .dec_fire(dec_fire), .dec_tag(dec_tag), .flush(flush),
  .wb_grant(wb_grant), .wb_steal(wb_steal), .wb_tag(wb_tag),
  .rob_head(rob_head), .rob_cnt(rob_cnt), .pfree_cnt(pfree_cnt),
  .req_age(req_age), .victim_age(victim_age), .cm_ok(cm_ok)
);

// File: tb/test_vpr_renamer.sv
module test_vpr_renamer;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 32, NVP = 64, NPHYS = 48, NRR = 4, NROB = 16;
  localparam int LW = $clog2(NLOG), VW = $clog2(NVP), PW = $clog2(NPHYS), RW = $clog2(NROB);

  logic clk = 0, rst = 1;
  logic dec_valid = 0, wb_valid = 0, cm_valid = 0, flush = 0;
  logic [LW-1:0] dec_dst = 0, dec_src_a = 0, dec_src_b = 0;
  logic [RW-1:0] wb_tag = 0;
  logic dec_ready, src_a_bound, src_b_bound, wb_grant, wb_steal, wb_replay, cm_ok;
  logic [VW-1:0] dec_vp, src_a_vp, src_b_vp;
  logic [RW-1:0] dec_tag, wb_victim;
  logic [PW-1:0] src_a_preg, src_b_preg, wb_preg;

  vpr_renamer #(.NLOG(NLOG), .NVP(NVP), .NPHYS(NPHYS), .NRR(NRR), .NROB(NROB)) i_vpr_renamer (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_dst(dec_dst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_ready(dec_ready),
    .dec_vp(dec_vp), .dec_tag(dec_tag), .src_a_vp(src_a_vp), .src_a_preg(src_a_preg),
    .src_a_bound(src_a_bound), .src_b_vp(src_b_vp), .src_b_preg(src_b_preg),
    .src_b_bound(src_b_bound), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_grant(wb_grant), .wb_preg(wb_preg), .wb_steal(wb_steal),
    .wb_victim(wb_victim), .wb_replay(wb_replay), .cm_valid(cm_valid),
    .cm_ok(cm_ok), .flush(flush)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference state.
  int m_gmap [NLOG], m_cmap [NLOG], m_v2p [NVP];
  bit m_bound [NVP], m_vfree [NVP], m_pfree [NPHYS];
  bit q_v [NROB], q_done [NROB];
  int q_log [NROB], q_vp [NROB], q_prev [NROB];
  int head, tail, fill;
  int nvec = 0, nfail = 0;

  // Expected values for the current cycle.
  bit e_ready, e_grant, e_steal, e_replay, e_cm, e_fire, e_free;
  int e_vp, e_preg, e_victim, lowp, best;

  function automatic int age(int i);
    return (i - head + NROB) % NROB;
  endfunction

  task automatic chk(string req, string sig, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NLOG; i++) begin m_gmap[i] = i; m_cmap[i] = i; end
    for (int v = 0; v < NVP; v++) begin
      m_v2p[v] = (v < NLOG) ? v : 0; m_bound[v] = (v < NLOG); m_vfree[v] = (v >= NLOG);
    end
    for (int p = 0; p < NPHYS; p++) m_pfree[p] = (p >= NLOG);
    for (int k = 0; k < NROB; k++) begin q_v[k] = 0; q_done[k] = 0; end
    head = 0; tail = 0; fill = 0;
  endtask

  task automatic model_eval();
    int lowv, pc, bage;
    bit hit;
    lowv = -1; lowp = -1; pc = 0;
    for (int v = NVP - 1; v >= 0; v--) if (m_vfree[v]) lowv = v;
    for (int p = NPHYS - 1; p >= 0; p--) if (m_pfree[p]) begin lowp = p; pc++; end
    e_ready = (fill < NROB) && (lowv >= 0);
    e_vp    = (lowv < 0) ? 0 : lowv;
    e_fire  = dec_valid && e_ready && !flush;
    hit = wb_valid && !flush && q_v[wb_tag] && !q_done[wb_tag];
    e_free = hit && (pc > NRR || (int'(wb_tag) == head && pc > 0));
    best = -1; bage = age(int'(wb_tag));
    for (int j = 0; j < NROB; j++)
      if (q_v[j] && q_done[j] && age(j) > bage) begin best = j; bage = age(j); end
    e_steal  = hit && !e_free && best >= 0;
    e_replay = hit && !e_free && best < 0;
    e_grant  = e_free || e_steal;
    e_preg   = e_free ? lowp : (e_steal ? m_v2p[q_vp[best]] : 0);
    e_victim = e_steal ? best : 0;
    e_cm     = cm_valid && !flush && q_v[head] && q_done[head];
  endtask

  task automatic model_apply();
    if (flush) begin
      for (int v = 0; v < NVP; v++) begin m_vfree[v] = 1; m_bound[v] = 0; end
      for (int p = 0; p < NPHYS; p++) m_pfree[p] = 1;
      for (int i = 0; i < NLOG; i++) begin
        m_gmap[i] = m_cmap[i]; m_vfree[m_cmap[i]] = 0; m_bound[m_cmap[i]] = 1;
        m_pfree[m_v2p[m_cmap[i]]] = 0;
      end
      for (int k = 0; k < NROB; k++) begin q_v[k] = 0; q_done[k] = 0; end
      head = 0; tail = 0; fill = 0;
      return;
    end
    if (e_fire) begin
      q_v[tail] = 1; q_done[tail] = 0; q_log[tail] = dec_dst; q_vp[tail] = e_vp;
      q_prev[tail] = m_gmap[dec_dst];
      m_gmap[dec_dst] = e_vp; m_vfree[e_vp] = 0; m_bound[e_vp] = 0;
      tail = (tail + 1) % NROB;
    end
    if (e_grant) begin
      m_v2p[q_vp[wb_tag]] = e_preg; m_bound[q_vp[wb_tag]] = 1; q_done[wb_tag] = 1;
      if (e_free) m_pfree[lowp] = 0;
    end
    if (e_steal) begin m_bound[q_vp[best]] = 0; q_done[best] = 0; end
    if (e_cm) begin
      m_vfree[q_prev[head]] = 1; m_pfree[m_v2p[q_prev[head]]] = 1; m_bound[q_prev[head]] = 0;
      m_cmap[q_log[head]] = q_vp[head]; q_v[head] = 0; head = (head + 1) % NROB;
    end
    fill = fill + int'(e_fire) - int'(e_cm);
  endtask

  task automatic compare_all();
    chk("R3", "dec_ready", dec_ready, e_ready);
    chk("R2", "dec_vp", dec_vp, e_vp);
    chk("R2", "dec_tag", dec_tag, tail);
    chk("R2", "src_a_vp", src_a_vp, m_gmap[dec_src_a]);
    chk("R4", "src_a_preg", src_a_preg, m_v2p[m_gmap[dec_src_a]]);
    chk("R4", "src_a_bound", src_a_bound, m_bound[m_gmap[dec_src_a]]);
    chk("R2", "src_b_vp", src_b_vp, m_gmap[dec_src_b]);
    chk("R4", "src_b_preg", src_b_preg, m_v2p[m_gmap[dec_src_b]]);
    chk("R4", "src_b_bound", src_b_bound, m_bound[m_gmap[dec_src_b]]);
    chk("R4", "wb_grant", wb_grant, e_grant);
    chk("R4", "wb_preg", wb_preg, e_preg);
    chk("R6", "wb_steal", wb_steal, e_steal);
    chk("R6", "wb_victim", wb_victim, e_victim);
    chk("R7", "wb_replay", wb_replay, e_replay);
    chk("R8", "cm_ok", cm_ok, e_cm);
  endtask

  // Inputs are set at the falling edge; sample 1 unit later, advance model at rise.
  task automatic cycle();
    #1;
    model_eval();
    compare_all();
    @(posedge clk);
    model_apply();
    @(negedge clk);
  endtask

  task automatic idle();
    dec_valid = 0; wb_valid = 0; cm_valid = 0; flush = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog (all) actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    dec_src_a = 5; dec_src_b = 31;
    #1;
    chk("R1", "dec_vp", dec_vp, 32);
    chk("R1", "dec_tag", dec_tag, 0);
    chk("R1", "dec_ready", dec_ready, 1);
    chk("R1", "src_a_vp", src_a_vp, 5);
    chk("R1", "src_a_preg", src_a_preg, 5);
    chk("R1", "src_b_bound", src_b_bound, 1);
    cycle();

    // R2: rename logical 1 twice; second lookup sees the first rename, unbound.
    dec_valid = 1; dec_dst = 1; dec_src_a = 1; dec_src_b = 2;
    #1; chk("R2", "src_a_vp_before", src_a_vp, 1); chk("R2", "dec_vp_first", dec_vp, 32);
    cycle();
    #1; chk("R2", "src_a_vp_renamed", src_a_vp, 32); chk("R2", "src_a_bound_new", src_a_bound, 0);
    // Fill the reorder record with 16 decodes in total.
    for (int k = 1; k < NROB; k++) begin
      dec_dst = LW'(k % 8 + 1); dec_src_a = LW'(k % 5); dec_src_b = LW'(k % 8 + 1);
      cycle();
    end
    #1; chk("R3", "dec_ready_full", dec_ready, 0);
    cycle();
    idle();

    // R4: write back slots 15 down to 4 from the open pool.
    for (int k = NROB - 1; k >= 4; k--) begin
      wb_valid = 1; wb_tag = RW'(k);
      cycle();
    end
    wb_tag = 3;
    #1; chk("R6", "wb_steal", wb_steal, 1); chk("R6", "wb_victim", wb_victim, 15);
    cycle();
    wb_tag = 15;
    #1; chk("R7", "wb_replay", wb_replay, 1); chk("R7", "wb_grant", wb_grant, 0);
    cycle();
    wb_tag = 0;
    #1; chk("R5", "wb_grant_head", wb_grant, 1); chk("R5", "wb_preg_head", wb_preg, 44);
    cycle();
    #1; chk("R10", "wb_grant_done", wb_grant, 0); chk("R10", "wb_replay_done", wb_replay, 0);
    cycle();
    wb_valid = 0; cm_valid = 1;
    #1; chk("R8", "cm_ok_head", cm_ok, 1);
    cycle();
    #1; chk("R8", "cm_ok_notdone", cm_ok, 0);
    cycle();
    cm_valid = 0; flush = 1; dec_valid = 1;
    cycle();
    idle(); dec_src_a = 1; dec_src_b = 2;
    #1;
    chk("R9", "dec_tag", dec_tag, 0);
    chk("R9", "src_a_vp", src_a_vp, 32);
    chk("R9", "src_a_preg", src_a_preg, 44);
    chk("R9", "src_a_bound", src_a_bound, 1);
    chk("R9", "src_b_vp", src_b_vp, 2);
    chk("R9", "dec_vp", dec_vp, 1);
    cycle();

    // Pseudo-random traffic, compared every cycle against the model.
    lf = 32'h1d2c_3b4a;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      dec_valid = lf[0]; dec_dst = lf[5:1]; dec_src_a = lf[10:6]; dec_src_b = lf[15:11];
      wb_valid = lf[16] | lf[17]; wb_tag = lf[21:18];
      cm_valid = lf[22] & lf[23];
      flush = (lf[30:24] == 7'd0);
      cycle();
    end
    idle();
    cycle();

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule